// File: doc/BRIEF.md
# Dual-Channel Timer Compare Output Unit

This block turns the count of an external 16-bit up-counting timer into two output waveforms, channel A and channel B. Software programs two compare values, a 4-bit waveform-generation mode and a 2-bit output action code per channel through a four-entry register interface. On every enabled timer tick the block looks for a compare match on each channel and for the counter sitting at BOTTOM (zero). It then sets, clears or toggles each channel's waveform bit, or leaves it alone.

How an action code is read depends on the waveform mode. In the non-PWM modes (normal and clear-on-match) the code picks an action that fires on a compare match. In the fast PWM modes the code picks a non-inverting or an inverting pair of actions, one on match and one at BOTTOM. A channel that claims its pin asserts an output-enable. The enable is qualified by that channel's direction-enable input, which stands in for the pad driver. A channel that does not claim its pin keeps its waveform bit frozen.

Register map. Address 0 is the control byte: channel A action code in bits 7:6, channel B action code in bits 5:4, waveform mode bits 1:0 in bits 1:0, and bits 3:2 always reading zero. Address 1 holds waveform mode bits 3:2 in its bits 1:0. Addresses 2 and 3 hold the channel A and channel B compare values. Every register resets to zero. A read returns the addressed register combinationally.

Top module: `dual_compare_output`

## Requirements
- R1: After reset every register reads zero. In the control byte at address 0, bits 3:2 always read zero, and all other control bits read back what was last written.
- R2: `oeA`/`oeB` is high exactly when the channel is connected and its direction-enable input is high. A channel is connected when its action code is nonzero, except in the case R7 names.
- R3: In the non-PWM modes (waveform mode 0, 4 or 12), action code 01 inverts the waveform bit on a tick whose count equals the channel's compare value.
- R4: In the non-PWM modes, action code 10 drives the waveform bit to 0 on a compare match, and code 11 drives it to 1.
- R5: In the fast PWM modes (5, 6, 7, 14, 15), action code 10 drives the bit to 0 on a compare match and to 1 on a tick with count 0 (BOTTOM).
- R6: In the fast PWM modes, action code 11 drives the bit to 1 on a compare match and to 0 at BOTTOM.
- R7: In the fast PWM modes, action code 01 connects only channel A, and only in modes 14 and 15, where it inverts the bit on a match. In any other fast PWM mode, and always for channel B, it leaves the channel disconnected (output-enable low, bit held).
- R8: Action code 00 disconnects the channel in every mode. A disconnected channel holds its waveform bit, and after reconnection it continues from the held value.
- R9: In fast PWM, when a compare match and BOTTOM fall on the same tick (compare value 0), the match action is applied and the BOTTOM action is dropped.
- R10: Without a tick no waveform bit changes. In the waveform modes not listed in R3 and R5, a connected channel holds its bit.
- R11: Both waveform bits reset to 0, and the compare registers read back the 16-bit value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read data of the addressed register |
| tmrTick | input | 1 | Timer count enable for this cycle |
| tmrCount | input | 16 | Current timer count |
| dirEnA | input | 1 | Direction enable of pin A |
| dirEnB | input | 1 | Direction enable of pin B |
| waveA | output | 1 | Channel A waveform level |
| waveB | output | 1 | Channel B waveform level |
| oeA | output | 1 | Pin A driven by channel A |
| oeB | output | 1 | Pin B driven by channel B |

## Verification
In fast PWM a compare match and the BOTTOM condition can fall on one tick when a compare value is zero and the counter reaches zero. The bench sets up this collision in both the non-inverting and the inverting setting. Beforehand it puts the waveform bit at the level the BOTTOM action would produce, so the result after the tick shows which action won. The sweep also passes count 0 through every compare setting, so the collision comes up in ordinary traffic, where a per-tick model judges it.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;
  localparam int NUM_CH = 2;
  localparam int COM_W  = 2;
  localparam int MODE_W = 4;
  localparam logic [MODE_W-1:0] TOGGLE_MODE_MIN = 4'd14;

  typedef enum logic [1:0] {
    CLS_NONPWM,
    CLS_FAST,
    CLS_OTHER
  } wgmClass_t;

  typedef struct packed {
    logic connect;
    logic setW;
    logic clrW;
    logic togW;
  } chStrobe_t;

  function automatic wgmClass_t classifyMode(input logic [MODE_W-1:0] m);
    wgmClass_t c;
    case (m)
      4'd0, 4'd4, 4'd12:               c = CLS_NONPWM;
      4'd5, 4'd6, 4'd7, 4'd14, 4'd15:  c = CLS_FAST;
      default:                         c = CLS_OTHER;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/dcmp_regs.sv
module dcmp_regs
  import dcmp_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int AW    = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wrEn,
  input  logic [AW-1:0]                      addr,
  input  logic [CNT_W-1:0]                   wrData,
  output logic [CNT_W-1:0]                   rdData,
  output logic [NUM_CH-1:0][COM_W-1:0]       comOut,
  output logic [MODE_W-1:0]                  modeOut,
  output logic [NUM_CH-1:0][CNT_W-1:0]       cmpOut
);
  localparam logic [AW-1:0] CTRL_ADDR  = AW'(0);
  localparam logic [AW-1:0] MODEH_ADDR = AW'(1);
  localparam int            CMP_BASE   = 2;

  logic [NUM_CH-1:0][COM_W-1:0] comReg;
  logic [1:0]                   modeLo;
  logic [1:0]                   modeHi;
  logic [NUM_CH-1:0][CNT_W-1:0] cmpReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      comReg <= '0;
      modeLo <= '0;
      modeHi <= '0;
    end else if (wrEn) begin
      if (addr == CTRL_ADDR) begin
        comReg[0] <= wrData[7:6];
        comReg[1] <= wrData[5:4];
        modeLo    <= wrData[1:0];
      end
      if (addr == MODEH_ADDR) modeHi <= wrData[1:0];
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rst_n) cmpReg[ch] <= '0;
      else if (wrEn && addr == AW'(CMP_BASE + ch)) cmpReg[ch] <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == CTRL_ADDR)  rdData[7:0] = {comReg[0], comReg[1], 2'b00, modeLo};
    if (addr == MODEH_ADDR) rdData[1:0] = modeHi;
    for (int i = 0; i < NUM_CH; i++)
      if (addr == AW'(CMP_BASE + i)) rdData = cmpReg[i];
  end

  assign comOut  = comReg;
  assign modeOut = {modeHi, modeLo};
  assign cmpOut  = cmpReg;

  // R1: a control write lands in the action codes seen by the control logic
  assert_ctrl_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr == CTRL_ADDR) |=> (comOut[0] == $past(wrData[7:6]) && comOut[1] == $past(wrData[5:4])));
endmodule

// File: rtl/dcmp_ctrl.sv
module dcmp_ctrl
  import dcmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic [CNT_W-1:0]              count,
  input  logic [MODE_W-1:0]             mode,
  input  logic [NUM_CH-1:0][COM_W-1:0]  com,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  cmp,
  output chStrobe_t [NUM_CH-1:0]        strobe
);
  wgmClass_t cls;
  logic      toggleModeOk;
  logic      atBottom;

  assign cls          = classifyMode(mode);
  assign toggleModeOk = (mode >= TOGGLE_MODE_MIN);
  assign atBottom     = tick && (count == '0);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam bit IS_A = (ch == 0);
    logic      match;
    chStrobe_t st;

    assign match = tick && (count == cmp[ch]);

    always_comb begin
      st = '0;
      unique case (cls)
        CLS_NONPWM: begin
          st.connect = (com[ch] != 2'b00);
          if (match) begin
            st.togW = (com[ch] == 2'b01);
            st.clrW = (com[ch] == 2'b10);
            st.setW = (com[ch] == 2'b11);
          end
        end
        CLS_FAST: begin
          unique case (com[ch])
            2'b01: begin
              if (IS_A && toggleModeOk) begin
                st.connect = 1'b1;
                st.togW    = match;
              end
            end
            2'b10: begin
              st.connect = 1'b1;
              st.clrW    = match;
              st.setW    = !match && atBottom;
            end
            2'b11: begin
              st.connect = 1'b1;
              st.setW    = match;
              st.clrW    = !match && atBottom;
            end
            default: ;
          endcase
        end
        default: st.connect = (com[ch] != 2'b00);
      endcase
    end

    assign strobe[ch] = st;

    // R9: at most one waveform action per channel per tick
    assert_single_action_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({strobe[ch].setW, strobe[ch].clrW, strobe[ch].togW}));

    // R10: no action without a tick
    assert_no_action_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |-> !(strobe[ch].setW || strobe[ch].clrW || strobe[ch].togW));
  end

  // R7: channel B never toggles in fast PWM
  assert_b_no_fast_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_FAST) |-> !strobe[1].togW);
endmodule

// File: rtl/dcmp_wave.sv
module dcmp_wave
  import dcmp_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  chStrobe_t [NUM_CH-1:0] strobe,
  output logic [NUM_CH-1:0]      wave
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)                wave[ch] <= 1'b0;
      else if (strobe[ch].togW)  wave[ch] <= ~wave[ch];
      else if (strobe[ch].setW)  wave[ch] <= 1'b1;
      else if (strobe[ch].clrW)  wave[ch] <= 1'b0;
    end

    // R8: a released channel keeps its level
    assert_hold_disconnected_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe[ch].connect |=> $stable(wave[ch]));

    // R3: a toggle strobe inverts the level
    assert_toggle_flips_R3: assert property (@(posedge clk) disable iff (!rst_n)
      strobe[ch].togW |=> (wave[ch] != $past(wave[ch])));
  end
endmodule

// File: rtl/dual_compare_output.sv
module dual_compare_output
  import dcmp_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int AW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             regWrEn,
  input  logic [AW-1:0]    regAddr,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] regRdData,
  input  logic             tmrTick,
  input  logic [CNT_W-1:0] tmrCount,
  input  logic             dirEnA,
  input  logic             dirEnB,
  output logic             waveA,
  output logic             waveB,
  output logic             oeA,
  output logic             oeB
);
  logic [NUM_CH-1:0][COM_W-1:0] com;
  logic [MODE_W-1:0]            mode;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp;
  chStrobe_t [NUM_CH-1:0]       strobe;
  logic [NUM_CH-1:0]            wave;

  dcmp_regs #(.CNT_W(CNT_W), .AW(AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wrEn(regWrEn), .addr(regAddr),
    .wrData(regWrData), .rdData(regRdData),
    .comOut(com), .modeOut(mode), .cmpOut(cmp)
  );

  dcmp_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .tick(tmrTick), .count(tmrCount),
    .mode(mode), .com(com), .cmp(cmp), .strobe(strobe)
  );

  dcmp_wave wave_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wave(wave)
  );

  assign waveA = wave[0];
  assign waveB = wave[1];
  assign oeA   = strobe[0].connect && dirEnA;
  assign oeB   = strobe[1].connect && dirEnB;
endmodule

// File: tb/dual_compare_output_tb.sv
`timescale 1ns/1ps
module dual_compare_output_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        regWrEn;
  logic [1:0]  regAddr;
  logic [15:0] regWrData;
  logic [15:0] regRdData;
  logic        tmrTick;
  logic [15:0] tmrCount;
  logic        dirEnA, dirEnB;
  logic        waveA, waveB, oeA, oeB;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0]  curMode;
  logic [1:0]  curCom [2];
  logic [15:0] curCmp [2];
  logic        expW   [2];

  always #2 clk = ~clk;

  dual_compare_output dut_i (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .tmrTick(tmrTick),
    .tmrCount(tmrCount), .dirEnA(dirEnA), .dirEnB(dirEnB),
    .waveA(waveA), .waveB(waveB), .oeA(oeA), .oeB(oeB)
  );

  // stimulus table: waveform mode and the two compare values
  localparam int NV = 9;
  localparam logic [3:0]  V_MODE [NV] = '{4'd0, 4'd4, 4'd12, 4'd5, 4'd6, 4'd7, 4'd14, 4'd15, 4'd1};
  localparam logic [15:0] V_CMPA [NV] = '{16'd3, 16'd2, 16'd0, 16'd4, 16'd1, 16'd0, 16'd3, 16'd5, 16'd2};
  localparam logic [15:0] V_CMPB [NV] = '{16'd5, 16'd0, 16'd4, 16'd2, 16'd0, 16'd3, 16'd1, 16'd2, 16'd4};

  function automatic bit isNon(input logic [3:0] m);
    return (m == 0 || m == 4 || m == 12);
  endfunction
  function automatic bit isFast(input logic [3:0] m);
    return (m == 5 || m == 6 || m == 7 || m == 14 || m == 15);
  endfunction
  function automatic bit modelConn(input int ch, input logic [3:0] m, input logic [1:0] c);
    if (c == 2'b00) return 1'b0;
    if (isFast(m) && c == 2'b01) return (ch == 0 && (m == 14 || m == 15));
    return 1'b1;
  endfunction
  function automatic logic modelStep(input int ch, input logic w, input logic [3:0] m,
                                     input logic [1:0] c, input logic [15:0] cnt, input logic [15:0] cv);
    bit mt, bt;
    mt = (cnt == cv);
    bt = (cnt == 16'd0);
    if (!modelConn(ch, m, c)) return w;
    if (isNon(m)) begin
      if (!mt) return w;
      if (c == 2'b01) return ~w;
      return (c == 2'b11);
    end
    if (isFast(m)) begin
      if (c == 2'b01) return mt ? ~w : w;
      if (mt) return (c == 2'b11);
      if (bt) return (c == 2'b10);
      return w;
    end
    return w;
  endfunction
  function automatic string reqTag(input logic [3:0] m, input logic [1:0] c);
    if (c == 2'b00) return "R8";
    if (isNon(m)) return (c == 2'b01) ? "R3" : "R4";
    if (isFast(m)) return (c == 2'b01) ? "R7" : (c == 2'b10) ? "R5" : "R6";
    return "R10";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic cfg(input logic [3:0] m, input logic [1:0] ca, input logic [1:0] cb);
    curMode = m; curCom[0] = ca; curCom[1] = cb;
    wr(2'd0, {8'h00, ca, cb, 2'b00, m[1:0]});
    wr(2'd1, {14'h0, m[3:2]});
  endtask

  task automatic setCmp(input logic [15:0] a, input logic [15:0] b);
    curCmp[0] = a; curCmp[1] = b;
    wr(2'd2, a);
    wr(2'd3, b);
  endtask

  // one tick: drive, model, then check wave and output enable one cycle later
  task automatic doTick(input logic [15:0] cnt, input bit en);
    @(negedge clk);
    tmrTick = en; tmrCount = cnt;
    if (en)
      for (int ch = 0; ch < 2; ch++)
        expW[ch] = modelStep(ch, expW[ch], curMode, curCom[ch], cnt, curCmp[ch]);
    @(negedge clk);
    tmrTick = 1'b0;
    check({reqTag(curMode, curCom[0]), " waveA"}, 32'(waveA), 32'(expW[0]));
    check({reqTag(curMode, curCom[1]), " waveB"}, 32'(waveB), 32'(expW[1]));
    check("R2 oeA", 32'(oeA), 32'(modelConn(0, curMode, curCom[0]) && dirEnA));
    check("R2 oeB", 32'(oeB), 32'(modelConn(1, curMode, curCom[1]) && dirEnB));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    tmrTick = 1'b0; tmrCount = '0; dirEnA = 1'b1; dirEnB = 1'b1;
    curMode = '0; curCom[0] = '0; curCom[1] = '0; curCmp[0] = '0; curCmp[1] = '0;
    expW[0] = 1'b0; expW[1] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state: R1, R11
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R1 reset reg", 32'(d), 32'h0);
    end
    check("R11 reset waveA", 32'(waveA), 32'h0);
    check("R11 reset waveB", 32'(waveB), 32'h0);
    check("R2 reset oeA", 32'(oeA), 32'h0);

    // reserved control bits: R1
    wr(2'd0, 16'h00FF);
    rd(2'd0, d);
    check("R1 ctrl readback", 32'(d), 32'hF3);
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h1234);
    rd(2'd2, d);
    check("R11 cmpA readback", 32'(d), 32'h1234);
    wr(2'd3, 16'hBEEF);
    rd(2'd3, d);
    check("R11 cmpB readback", 32'(d), 32'hBEEF);

    // table sweep over modes and every action code
    for (int v = 0; v < NV; v++) begin
      dirEnB = v[0];
      setCmp(V_CMPA[v], V_CMPB[v]);
      for (int c = 0; c < 4; c++) begin
        cfg(V_MODE[v], 2'(c), 2'((c + 1) % 4));
        rd(2'd1, d);
        check("R1 mode high readback", 32'(d), 32'(V_MODE[v][3:2]));
        for (int k = 0; k < 14; k++) doTick(16'(k % 6), 1'b1);
      end
    end
    dirEnB = 1'b1;

    // R9: collision of match and BOTTOM, non-inverting
    cfg(4'd14, 2'b11, 2'b00);
    setCmp(16'd3, 16'd0);
    doTick(16'd3, 1'b1);
    check("R9 preset high", 32'(waveA), 32'h1);
    cfg(4'd14, 2'b10, 2'b00);
    setCmp(16'd0, 16'd0);
    doTick(16'd0, 1'b1);
    check("R9 match wins clear", 32'(waveA), 32'h0);
    // R9: inverting
    cfg(4'd5, 2'b11, 2'b00);
    doTick(16'd0, 1'b1);
    check("R9 match wins set", 32'(waveA), 32'h1);

    // R10: no tick, no change
    cfg(4'd0, 2'b01, 2'b00);
    setCmp(16'd7, 16'd0);
    doTick(16'd7, 1'b0);
    check("R10 idle hold", 32'(waveA), 32'h1);

    // R8: disconnect holds, reconnect resumes
    cfg(4'd4, 2'b10, 2'b00);
    doTick(16'd7, 1'b1);
    check("R8 cleared", 32'(waveA), 32'h0);
    cfg(4'd4, 2'b11, 2'b00);
    doTick(16'd7, 1'b1);
    check("R8 set", 32'(waveA), 32'h1);
    cfg(4'd4, 2'b00, 2'b00);
    doTick(16'd7, 1'b1);
    doTick(16'd0, 1'b1);
    check("R8 held while off", 32'(waveA), 32'h1);
    check("R8 oe off", 32'(oeA), 32'h0);
    cfg(4'd4, 2'b01, 2'b00);
    check("R8 resume level", 32'(waveA), 32'h1);
    doTick(16'd7, 1'b1);
    check("R8 toggle after resume", 32'(waveA), 32'h0);

    // R7: channel B toggle code in mode 15 stays released
    cfg(4'd15, 2'b01, 2'b01);
    setCmp(16'd2, 16'd2);
    doTick(16'd2, 1'b1);
    check("R7 B released", 32'(oeB), 32'h0);

    // R2: direction enable gates the output enable
    dirEnA = 1'b0;
    #1 check("R2 oeA gated", 32'(oeA), 32'h0);
    dirEnA = 1'b1;
    #1 check("R2 oeA open", 32'(oeA), 32'h1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule